// File: doc/BRIEF.md
# Compare/Capture Event Channels for a Real-Time Counter

This block watches a running real-time counter through a 32-bit compact time word and turns it into events on three channels. The compact word carries the low 16 bits of the seconds count above the high 16 bits of the fraction, so one unit of the low half is 1/65536 s. For example, 0x00058000 stands for 5.5 s. Each channel keeps a compare value. When the compact time has reached the compare value, or has passed it by less than one second, the channel raises a sticky flag and emits a one-cycle pulse. Software clears a flag by writing a one to it.

Channel 0 only compares. Channel 1 can be switched into a capture mode. In that mode a rising edge on an external trigger stores the current compact time and raises the channel 1 event. Channel 2 can run continuously: after each of its events it adds a programmable step to its own compare value and re-arms itself, which gives a periodic wake-up with no software involvement. A compare is evaluated on every cycle in which the surrounding counter reports that time advanced. It is also evaluated once right after a new compare value is written, so a value written slightly in the past still produces its event at once.

Top module: `rtc_evt_channels`

## Requirements
- R1: After reset the flags, the event pulses, the capture value and the channel 2 compare value are all zero.
- R2: An enabled, armed compare channel fires when it is evaluated and (time − compare) mod 2^32 < 0x10000. It is evaluated in a cycle where the tick input is high, and the flag and pulse appear at the next clock edge.
- R3: In the cycle after a compare write, the new value is evaluated without a tick. A difference of 0xFFFF fires. A difference of exactly 0x10000 (one second in the past) does not.
- R4: A compare value later than the current time produces no event until a tick presents a time that has reached it.
- R5: A compare write arms its channel. A non-continuous channel disarms when it fires, so later ticks inside the window raise no further event until the next write.
- R6: A channel whose enable is low never raises its flag or pulse, and it keeps its armed state. Once enabled, the next tick inside the window fires.
- R7: A one on a flag-clear bit clears that flag and no other. If the same flag is set and cleared in one cycle, it ends up set.
- R8: With channel 1 enabled and in capture mode, a 0-to-1 trigger transition stores the compact time in the capture value and raises the channel 1 event. A trigger held high captures nothing more, and channel 1 compares are suppressed in this mode. Outside capture mode the trigger has no effect.
- R9: With continuous mode on, each channel 2 compare event adds the step input to the channel 2 compare value at the same edge, and the channel stays armed. With continuous mode off, the compare value is left unchanged.
- R10: Each event produces a pulse that lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 32 | Compact time: seconds[15:0] above fraction[31:16] |
| timeTick | input | 1 | High for one cycle when timeNow has advanced |
| cmpWrEn | input | 3 | Per-channel compare write strobe |
| cmpWrData | input | 32 | Compare value to write |
| chEnable | input | 3 | Per-channel enable |
| capMode | input | 1 | Channel 1 capture mode select |
| contMode | input | 1 | Channel 2 continuous mode select |
| incValue | input | 32 | Step added to the channel 2 compare value |
| capTrig | input | 1 | Capture trigger level |
| flagClr | input | 3 | Write-one-to-clear for the flags |
| flags | output | 3 | Sticky event flags, one per channel |
| evtPulse | output | 3 | One-cycle event pulses |
| capValue | output | 32 | Last captured compact time |
| cmp2Value | output | 32 | Current channel 2 compare value |

## Verification
The bound checker watches a set of rules on every cycle:
- a pulse only ever follows a cycle in which its channel was enabled;
- a pulse always coincides with its flag being set;
- a cleared flag drops unless a new event lands in the same cycle;
- the capture value changes only together with a channel 1 event;
- the channel 2 compare value moves only on a write or a channel 2 event.

Some behaviours can only be shown by the bench's scenarios, because each depends on a sequence of writes and ticks:
- the exact edges of the look-back window (0xFFFF against 0x10000);
- an event staying silent until the time reaches a future compare value;
- a channel disarming after it fires;
- the exact step applied in continuous mode.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int NUM_CH  = 3;
  localparam int CAP_CH  = 1;
  localparam int CONT_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] cmpLoad;
    logic              cmpAdvance;
    logic              capLoad;
  } evtStrobes_t;
endpackage

// File: rtl/rtc_evt_datapath.sv
module rtc_evt_datapath
  import rtc_evt_pkg::*;
#(
  parameter int                TIME_W = 32,
  parameter logic [TIME_W-1:0] WINDOW = 32'h0001_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TIME_W-1:0]     timeNow,
  input  logic [TIME_W-1:0]     cmpWrData,
  input  logic [TIME_W-1:0]     incValue,
  input  evtStrobes_t           strobes,
  output logic [NUM_CH-1:0]     inWindow,
  output logic [TIME_W-1:0]     capValue,
  output logic [TIME_W-1:0]     cmp2Value
);
  logic [TIME_W-1:0] cmpReg [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [TIME_W-1:0] lag;
    assign lag         = timeNow - cmpReg[i];
    assign inWindow[i] = (lag < WINDOW);

    if (i == CONT_CH) begin : g_cont
      always_ff @(posedge clk) begin
        if (!rstN)                  cmpReg[i] <= '0;
        else if (strobes.cmpLoad[i]) cmpReg[i] <= cmpWrData;
        else if (strobes.cmpAdvance) cmpReg[i] <= cmpReg[i] + incValue;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)                  cmpReg[i] <= '0;
        else if (strobes.cmpLoad[i]) cmpReg[i] <= cmpWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               capValue <= '0;
    else if (strobes.capLoad) capValue <= timeNow;
  end

  assign cmp2Value = cmpReg[CONT_CH];
endmodule

// File: rtl/rtc_evt_control.sv
module rtc_evt_control
  import rtc_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              timeTick,
  input  logic [NUM_CH-1:0] cmpWrEn,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic              capMode,
  input  logic              contMode,
  input  logic              capTrig,
  input  logic [NUM_CH-1:0] flagClr,
  input  logic [NUM_CH-1:0] inWindow,
  output evtStrobes_t       strobes,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] evtPulse
);
  logic [NUM_CH-1:0] armed;
  logic [NUM_CH-1:0] wrPend;
  logic [NUM_CH-1:0] cmpHit;
  logic [NUM_CH-1:0] evt;
  logic              trigPrev;
  logic              capHit;

  assign capHit = chEnable[CAP_CH] & capMode & capTrig & ~trigPrev;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cmpModeOn;
    logic keepArmed;

    if (i == CAP_CH) begin : g_cap
      assign cmpModeOn = ~capMode;
      assign evt[i]    = cmpHit[i] | capHit;
    end else begin : g_nocap
      assign cmpModeOn = 1'b1;
      assign evt[i]    = cmpHit[i];
    end

    if (i == CONT_CH) begin : g_cont
      assign keepArmed = contMode;
    end else begin : g_once
      assign keepArmed = 1'b0;
    end

    assign cmpHit[i] = chEnable[i] & cmpModeOn & armed[i]
                     & (timeTick | wrPend[i]) & inWindow[i];

    always_ff @(posedge clk) begin
      if (!rstN)                       armed[i] <= 1'b0;
      else if (cmpWrEn[i])             armed[i] <= 1'b1;
      else if (cmpHit[i] && !keepArmed) armed[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      evtPulse <= '0;
      wrPend   <= '0;
      trigPrev <= 1'b0;
    end else begin
      flags    <= (flags & ~flagClr) | evt;
      evtPulse <= evt;
      wrPend   <= cmpWrEn;
      trigPrev <= capTrig;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.cmpLoad    = cmpWrEn;
    strobes.cmpAdvance = cmpHit[CONT_CH] & contMode & ~cmpWrEn[CONT_CH];
    strobes.capLoad    = capHit;
  end
endmodule

// File: rtl/rtc_evt_channels.sv
module rtc_evt_channels
  import rtc_evt_pkg::*;
#(
  parameter int                TIME_W = 32,
  parameter logic [TIME_W-1:0] WINDOW = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              timeTick,
  input  logic [NUM_CH-1:0] cmpWrEn,
  input  logic [TIME_W-1:0] cmpWrData,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic              capMode,
  input  logic              contMode,
  input  logic [TIME_W-1:0] incValue,
  input  logic              capTrig,
  input  logic [NUM_CH-1:0] flagClr,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] evtPulse,
  output logic [TIME_W-1:0] capValue,
  output logic [TIME_W-1:0] cmp2Value
);
  evtStrobes_t       strobes;
  logic [NUM_CH-1:0] inWindow;

  rtc_evt_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .timeTick (timeTick),
    .cmpWrEn  (cmpWrEn),
    .chEnable (chEnable),
    .capMode  (capMode),
    .contMode (contMode),
    .capTrig  (capTrig),
    .flagClr  (flagClr),
    .inWindow (inWindow),
    .strobes  (strobes),
    .flags    (flags),
    .evtPulse (evtPulse)
  );

  rtc_evt_datapath #(.TIME_W(TIME_W), .WINDOW(WINDOW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .timeNow   (timeNow),
    .cmpWrData (cmpWrData),
    .incValue  (incValue),
    .strobes   (strobes),
    .inWindow  (inWindow),
    .capValue  (capValue),
    .cmp2Value (cmp2Value)
  );
endmodule

// File: rtl/rtc_evt_channels_chk.sv
module rtc_evt_channels_chk
  import rtc_evt_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] cmpWrEn,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] flagClr,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] evtPulse,
  input logic [TIME_W-1:0] capValue,
  input logic [TIME_W-1:0] cmp2Value
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |-> $past(chEnable[i])); // R6
    AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |-> flags[i]); // R2
    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && flagClr[i]) |=> (!flags[i] || evtPulse[i])); // R7
  end

  AST_CAPTURE_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !evtPulse[CAP_CH] |-> $stable(capValue)); // R8
  AST_CMP2_MOVES_ON_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!evtPulse[CONT_CH] && !$past(cmpWrEn[CONT_CH])) |-> $stable(cmp2Value)); // R9
endmodule

bind rtc_evt_channels rtc_evt_channels_chk #(.TIME_W(TIME_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmpWrEn   (cmpWrEn),
  .chEnable  (chEnable),
  .flagClr   (flagClr),
  .flags     (flags),
  .evtPulse  (evtPulse),
  .capValue  (capValue),
  .cmp2Value (cmp2Value)
);

// File: tb/rtc_evt_channels_bench.sv
`timescale 1ns/1ps
module rtc_evt_channels_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] timeNow;
  logic        timeTick;
  logic [2:0]  cmpWrEn;
  logic [31:0] cmpWrData;
  logic [2:0]  chEnable;
  logic        capMode;
  logic        contMode;
  logic [31:0] incValue;
  logic        capTrig;
  logic [2:0]  flagClr;
  logic [2:0]  flags;
  logic [2:0]  evtPulse;
  logic [31:0] capValue;
  logic [31:0] cmp2Value;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  rtc_evt_channels u_rtc_evt_channels (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .timeTick(timeTick),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .chEnable(chEnable),
    .capMode(capMode), .contMode(contMode), .incValue(incValue),
    .capTrig(capTrig), .flagClr(flagClr), .flags(flags),
    .evtPulse(evtPulse), .capValue(capValue), .cmp2Value(cmp2Value)
  );

  function automatic logic inWin(input logic [31:0] t, input logic [31:0] c);
    logic [31:0] d;
    d = t - c;
    return d < 32'h0001_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic writeCmp(input int ch, input logic [31:0] v);
    cmpWrEn[ch] = 1'b1;
    cmpWrData   = v;
    cyc();
    cmpWrEn     = '0;
    cyc();
  endtask

  task automatic tick(input logic [31:0] t);
    timeNow  = t;
    timeTick = 1'b1;
    cyc();
    timeTick = 1'b0;
  endtask

  task automatic clearAll();
    flagClr = 3'b111;
    cyc();
    flagClr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd4242);
    rstN = 1'b0; timeNow = '0; timeTick = 0; cmpWrEn = '0; cmpWrData = '0;
    chEnable = '0; capMode = 0; contMode = 0; incValue = '0; capTrig = 0; flagClr = '0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    chk("R1 flags", {29'd0, flags}, 32'd0);
    chk("R1 pulse", {29'd0, evtPulse}, 32'd0);
    chk("R1 capValue", capValue, 32'd0);
    chk("R1 cmp2Value", cmp2Value, 32'd0);

    // future compare, then reach it
    chEnable = 3'b001;
    timeNow  = 32'h0001_0000;
    writeCmp(0, 32'h0005_8000);
    chk("R4 future write", {31'd0, flags[0]}, 32'd0);
    tick(32'h0005_0000);
    chk("R4 before reach", {31'd0, flags[0]}, 32'd0);
    tick(32'h0005_8000);
    chk("R2 reach flag", {31'd0, flags[0]}, 32'd1);
    chk("R10 pulse high", {31'd0, evtPulse[0]}, 32'd1);
    cyc();
    chk("R10 pulse one cycle", {31'd0, evtPulse[0]}, 32'd0);
    tick(32'h0005_8100);
    chk("R5 no refire", {31'd0, evtPulse[0]}, 32'd0);

    // clears
    flagClr = 3'b110; cyc(); flagClr = '0;
    chk("R7 other clear no effect", {31'd0, flags[0]}, 32'd1);
    flagClr = 3'b001; cyc(); flagClr = '0;
    chk("R7 clear", {31'd0, flags[0]}, 32'd0);

    // immediate on write and window edges
    writeCmp(0, 32'h0005_8100 - 32'h8000);
    chk("R3 past write fires", {31'd0, flags[0]}, 32'd1);
    clearAll();
    writeCmp(0, 32'h0005_8100 - 32'h1_0000);
    chk("R3 exactly one second no fire", {31'd0, flags[0]}, 32'd0);
    writeCmp(0, 32'h0005_8100 - 32'hFFFF);
    chk("R3 edge 0xFFFF fires", {31'd0, flags[0]}, 32'd1);

    // set and clear in one cycle
    writeCmp(0, 32'h0006_0000);
    timeNow = 32'h0006_0000; timeTick = 1; flagClr = 3'b001;
    cyc();
    timeTick = 0; flagClr = '0;
    chk("R7 set wins over clear", {31'd0, flags[0]}, 32'd1);

    // disabled channel
    clearAll();
    chEnable = 3'b000;
    writeCmp(0, 32'h0006_0000);
    chk("R6 disabled write", {31'd0, flags[0]}, 32'd0);
    tick(32'h0006_0010);
    chk("R6 disabled tick", {29'd0, evtPulse}, 32'd0);
    chEnable = 3'b001;
    tick(32'h0006_0020);
    chk("R6 armed kept after enable", {31'd0, flags[0]}, 32'd1);

    // capture
    clearAll();
    chEnable = 3'b010; capMode = 0;
    timeNow = 32'h1111_2222; capTrig = 1; cyc(); capTrig = 0; cyc();
    chk("R8 no capture outside mode", capValue, 32'd0);
    capMode = 1;
    timeNow = 32'h1234_5678; capTrig = 1; cyc();
    chk("R8 capture value", capValue, 32'h1234_5678);
    chk("R8 capture flag", {31'd0, flags[1]}, 32'd1);
    timeNow = 32'h1234_9999; cyc();
    chk("R8 held trigger", capValue, 32'h1234_5678);
    clearAll();
    writeCmp(1, 32'h1234_9999);
    chk("R8 compare suppressed", {31'd0, flags[1]}, 32'd0);
    capTrig = 0; cyc(); capTrig = 1; cyc();
    chk("R8 second capture", capValue, 32'h1234_9999);
    capTrig = 0; capMode = 0;

    // continuous
    clearAll();
    chEnable = 3'b100; contMode = 1; incValue = 32'h0001_0000;
    timeNow = 32'h0010_0000;
    writeCmp(2, 32'h0010_0000);
    chk("R9 first event", {31'd0, flags[2]}, 32'd1);
    chk("R9 advance", cmp2Value, 32'h0011_0000);
    clearAll();
    tick(32'h0011_0000);
    chk("R9 rearmed event", {31'd0, flags[2]}, 32'd1);
    chk("R9 second advance", cmp2Value, 32'h0012_0000);
    contMode = 0;
    writeCmp(2, 32'h0020_0000);
    tick(32'h0020_0000);
    chk("R9 noncont fires", {31'd0, evtPulse[2]}, 32'd1);
    chk("R9 noncont holds", cmp2Value, 32'h0020_0000);

    // random window checks on channel 0
    chEnable = 3'b001;
    for (int n = 0; n < 60; n++) begin
      logic [31:0] c, off, t;
      logic expHit;
      c = $urandom;
      case ($urandom % 5)
        0: off = $urandom % 32'h1_0000;
        1: off = 32'hFFFF;
        2: off = 32'h1_0000;
        3: off = 32'h1_0000 + ($urandom % 32'h7FFF_0000);
        default: off = -(32'd1 + ($urandom % 32'h7FFF));
      endcase
      t = c + off;
      clearAll();
      timeNow = t;
      writeCmp(0, c);
      expHit = inWin(t, c);
      chk("R3 random window flag", {31'd0, flags[0]}, {31'd0, expHit});
      chk("R10 random pulse", {31'd0, evtPulse[0]}, {31'd0, expHit});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule